// File: doc/BRIEF.md
# Relative Branch Target Generator

This block turns the opening byte of a relative branch or relative subroutine call into a resolved destination. An opcode byte is offered together with the address at which the instruction starts. The block classifies the byte, pulls any offset bytes that follow it from a byte stream, and produces one result record. The record holds the condition code, a call flag, the destination address and the instruction length in bytes.

Four encodings exist. The one-byte short form packs a 3-bit displacement into the opcode itself. That displacement is remapped rather than read as a signed field: codes 0, 1 and 2 stand for 8, 9 and 10, and codes 3 to 7 stand for themselves. The other forms take a signed offset of 8, 16 or 24 bits, supplied least significant byte first. The destination is always the start address plus the offset. Evaluating the condition against flags, pushing the return address and redirecting fetch are left to the blocks that consume the record.

Top module: `rbt_gen`

## Requirements
- R1: Opcode 0001_nddd is a one-byte conditional branch. It reports length 1, call 0, condition {000,n}, and destination start address plus the remapped short displacement.
- R2: The short displacement ddd maps 0→8, 1→9 and 2→10. Values 3 to 7 map to themselves.
- R3: Opcode 0000_1ddd is a one-byte branch that always applies. It reports condition 14 (4'hE means "always") and length 1.
- R4: Opcode 0010_cccc takes one offset byte, sign-extended from 8 bits. It reports condition cccc and length 2, so 0x2E reports condition 14.
- R5: Opcode 0011_101c takes two offset bytes and reports condition {000,c}. Opcode 0x38 reports condition 14. Both report length 3, and the offset is a signed 16-bit value taken low byte first.
- R6: Opcode 0x04 takes three offset bytes forming a signed 24-bit value, low byte first. It reports condition 14 and length 4.
- R7: Opcodes 0x39 (two offset bytes, length 3) and 0x05 (three offset bytes, length 4) are calls. They report call 1 and condition 14. Every other valid form reports call 0.
- R8: The destination is the start address plus the sign-extended offset, and it wraps modulo 2^32.
- R9: Any other opcode byte gives a result with invalid 1, length 0, call 0, condition 0 and destination 0. It fetches no offset bytes, so busy stays low.
- R10: res_valid is a one-cycle pulse. It rises in the cycle after the clock edge that accepts a one-byte or invalid opcode, or the cycle after the edge that accepts the last offset byte. Result fields hold until the next result.
- R11: busy is high from the cycle after a multi-byte opcode is accepted until its result appears. While busy is high, op_valid is ignored and no result is raised. A cycle without nb_valid simply waits. nb_valid is ignored while the block is idle.
- R12: During and straight after reset, res_valid, busy and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode byte offered; taken when busy is low |
| op_byte | input | 8 | First byte of the instruction |
| op_pc | input | ADDR_W | Start address of the instruction |
| nb_valid | input | 1 | Offset byte offered; taken when busy is high |
| nb_data | input | 8 | Next offset byte from the stream, low byte first |
| busy | output | 1 | Offset bytes are being gathered |
| res_valid | output | 1 | One-cycle result strobe |
| res_invalid | output | 1 | The opcode byte was not a relative branch or call |
| res_cond | output | 4 | Condition code; 14 means always |
| res_call | output | 1 | The instruction is a subroutine call |
| res_target | output | ADDR_W | Destination address |
| res_len | output | 3 | Instruction length in bytes (0 when invalid) |

## Verification
One-byte and invalid opcodes yield res_valid one cycle after the edge that takes them. Longer forms yield it one cycle after the edge that takes their last offset byte. Up to that point, every intermediate cycle shows busy high and res_valid low. The bench drives each input a short time after a rising edge and reads the outputs at the same point in the next cycle, so every sample falls exactly on the predicted cycle. It also checks that a stall cycle, a stray opcode during gathering or a stray offset byte while idle neither moves nor duplicates a result.

// File: rtl/rbt_pkg.sv
package rbt_pkg;

    localparam int OFF_LANES = 3;
    localparam int OFF_W     = OFF_LANES * 8;
    localparam int CNT_W     = $clog2(OFF_LANES + 1);
    localparam logic [3:0] COND_ALWAYS = 4'hE;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } rbt_state_e;

    typedef struct packed {
        logic             ok;
        logic             call;
        logic [3:0]       cond;
        logic [CNT_W-1:0] extra;
        logic [3:0]       short_off;
    } rbt_form_t;

    function automatic logic [3:0] short_remap(input logic [2:0] code);
        return (code < 3'd3) ? {1'b0, code} + 4'd8 : {1'b0, code};
    endfunction

endpackage

// File: rtl/rbt_classify.sv
module rbt_classify
    import rbt_pkg::*;
(
    input  logic [7:0] op,
    output rbt_form_t  form
);

    always_comb begin
        form = '0;
        casez (op)
            8'b0001_????: begin
                form.ok        = 1'b1;
                form.cond      = {3'b000, op[3]};
                form.short_off = short_remap(op[2:0]);
            end
            8'b0000_1???: begin
                form.ok        = 1'b1;
                form.cond      = COND_ALWAYS;
                form.short_off = short_remap(op[2:0]);
            end
            8'b0010_????: begin
                form.ok    = 1'b1;
                form.cond  = op[3:0];
                form.extra = CNT_W'(1);
            end
            8'b0011_101?: begin
                form.ok    = 1'b1;
                form.cond  = {3'b000, op[0]};
                form.extra = CNT_W'(2);
            end
            8'h38, 8'h39: begin
                form.ok    = 1'b1;
                form.call  = op[0];
                form.cond  = COND_ALWAYS;
                form.extra = CNT_W'(2);
            end
            8'h04, 8'h05: begin
                form.ok    = 1'b1;
                form.call  = op[0];
                form.cond  = COND_ALWAYS;
                form.extra = CNT_W'(3);
            end
            default: form = '0;
        endcase
    end

endmodule

// File: rtl/rbt_sext.sv
module rbt_sext #(
    parameter int LANES = 3,
    localparam int RAW_W = LANES * 8,
    localparam int NB_W  = $clog2(LANES + 1)
) (
    input  logic [RAW_W-1:0] raw,
    input  logic [NB_W-1:0]  nbytes,
    output logic [RAW_W-1:0] ext
);

    logic [LANES-1:0] lane_top;
    logic             sign;

    for (genvar L = 0; L < LANES; L++) begin : g_top
        assign lane_top[L] = raw[L*8+7];
    end

    always_comb begin
        sign = 1'b0;
        for (int L = 0; L < LANES; L++) begin
            if (nbytes == NB_W'(L + 1)) sign = lane_top[L];
        end
    end

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        assign ext[L*8 +: 8] = (NB_W'(L) < nbytes) ? raw[L*8 +: 8] : {8{sign}};
    end

endmodule

// File: rtl/rbt_gen.sv
module rbt_gen
    import rbt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_byte,
    input  logic [ADDR_W-1:0] op_pc,
    input  logic              nb_valid,
    input  logic [7:0]        nb_data,
    output logic              busy,
    output logic              res_valid,
    output logic              res_invalid,
    output logic [3:0]        res_cond,
    output logic              res_call,
    output logic [ADDR_W-1:0] res_target,
    output logic [2:0]        res_len
);

    typedef struct packed {
        rbt_state_e        st;
        logic [CNT_W-1:0]  need;
        logic [CNT_W-1:0]  got;
        logic [OFF_W-1:0]  acc;
        logic [ADDR_W-1:0] base;
        logic [3:0]        cond;
        logic              call;
        logic              rv;
        logic              rinv;
        logic [3:0]        rcond;
        logic              rcall;
        logic [ADDR_W-1:0] rtgt;
        logic [2:0]        rlen;
    } state_t;

    state_t            state_q, state_d;
    rbt_form_t         form;
    logic [OFF_W-1:0]  acc_ins;
    logic [OFF_W-1:0]  off_ext;
    logic [ADDR_W-1:0] off_full;

    rbt_classify u_classify (
        .op   (op_byte),
        .form (form)
    );

    always_comb begin
        acc_ins = state_q.acc;
        for (int L = 0; L < OFF_LANES; L++) begin
            if (state_q.got == CNT_W'(L)) acc_ins[L*8 +: 8] = nb_data;
        end
    end

    rbt_sext #(.LANES(OFF_LANES)) u_sext (
        .raw    (acc_ins),
        .nbytes (state_q.need),
        .ext    (off_ext)
    );

    assign off_full = {{(ADDR_W-OFF_W){off_ext[OFF_W-1]}}, off_ext};

    always_comb begin
        state_d    = state_q;
        state_d.rv = 1'b0;
        case (state_q.st)
            ST_IDLE: begin
                if (op_valid) begin
                    if (!form.ok) begin
                        state_d.rv    = 1'b1;
                        state_d.rinv  = 1'b1;
                        state_d.rcond = 4'd0;
                        state_d.rcall = 1'b0;
                        state_d.rtgt  = '0;
                        state_d.rlen  = 3'd0;
                    end else if (form.extra == '0) begin
                        state_d.rv    = 1'b1;
                        state_d.rinv  = 1'b0;
                        state_d.rcond = form.cond;
                        state_d.rcall = form.call;
                        state_d.rtgt  = op_pc + ADDR_W'(form.short_off);
                        state_d.rlen  = 3'd1;
                    end else begin
                        state_d.st   = ST_FETCH;
                        state_d.need = form.extra;
                        state_d.got  = '0;
                        state_d.acc  = '0;
                        state_d.base = op_pc;
                        state_d.cond = form.cond;
                        state_d.call = form.call;
                    end
                end
            end
            ST_FETCH: begin
                if (nb_valid) begin
                    state_d.acc = acc_ins;
                    state_d.got = state_q.got + CNT_W'(1);
                    if (state_q.got + CNT_W'(1) == state_q.need) begin
                        state_d.st    = ST_IDLE;
                        state_d.rv    = 1'b1;
                        state_d.rinv  = 1'b0;
                        state_d.rcond = state_q.cond;
                        state_d.rcall = state_q.call;
                        state_d.rtgt  = state_q.base + off_full;
                        state_d.rlen  = 3'(state_q.need) + 3'd1;
                    end
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy        = (state_q.st == ST_FETCH);
    assign res_valid   = state_q.rv;
    assign res_invalid = state_q.rinv;
    assign res_cond    = state_q.rcond;
    assign res_call    = state_q.rcall;
    assign res_target  = state_q.rtgt;
    assign res_len     = state_q.rlen;

    // R11: no result is raised while offset bytes are still outstanding
    a_r11_no_result_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !busy);

    // R9: an unrecognised opcode never starts gathering
    a_r9_invalid_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid && !form.ok) |=> (!busy && res_valid && res_invalid));

    // R9: invalid result record shape
    a_r9_invalid_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_invalid) |-> (res_len == 3'd0 && !res_call && res_cond == 4'd0));

    // R7: calls are unconditional and take an offset field
    a_r7_call_always: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_call) |-> (res_cond == COND_ALWAYS && res_len >= 3'd3));

    // R10: multi-byte results only follow a gathering phase
    a_r10_long_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_len > 3'd1) |-> $past(busy));

    // R11: the captured start address is frozen while gathering
    a_r11_base_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(state_q.base));

endmodule

// File: tb/rbt_gen_test.sv
`timescale 1ns/1ps
module rbt_gen_test;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [7:0]        op_byte = 8'h00;
    logic [ADDR_W-1:0] op_pc = '0;
    logic              nb_valid = 1'b0;
    logic [7:0]        nb_data = 8'h00;
    logic              busy, res_valid, res_invalid, res_call;
    logic [3:0]        res_cond;
    logic [ADDR_W-1:0] res_target;
    logic [2:0]        res_len;

    int nchecks = 0;
    int nerr    = 0;

    always #2 clk = ~clk;

    rbt_gen #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_byte(op_byte), .op_pc(op_pc),
        .nb_valid(nb_valid), .nb_data(nb_data),
        .busy(busy), .res_valid(res_valid), .res_invalid(res_invalid),
        .res_cond(res_cond), .res_call(res_call),
        .res_target(res_target), .res_len(res_len)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [31:0] pc;
        logic [23:0] bytes;
        logic [3:0]  cond;
        logic        call;
        logic [31:0] tgt;
        logic [2:0]  len;
        logic        inv;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 32'h0000_1000, 24'h0,       4'd0,  1'b0, 32'h0000_1008, 3'd1, 1'b0, 8'd1},  // R1 R2 code 0
        '{8'h1A, 32'h0000_2000, 24'h0,       4'd1,  1'b0, 32'h0000_200A, 3'd1, 1'b0, 8'd2},  // R2 code 2
        '{8'h13, 32'h0000_0100, 24'h0,       4'd0,  1'b0, 32'h0000_0103, 3'd1, 1'b0, 8'd2},  // R2 code 3
        '{8'h0F, 32'h0000_0040, 24'h0,       4'd14, 1'b0, 32'h0000_0047, 3'd1, 1'b0, 8'd3},  // R3 code 7
        '{8'h09, 32'hFFFF_FFFC, 24'h0,       4'd14, 1'b0, 32'h0000_0005, 3'd1, 1'b0, 8'd8},  // R8 R3 wrap
        '{8'h25, 32'h0000_1000, 24'h80,      4'd5,  1'b0, 32'h0000_0F80, 3'd2, 1'b0, 8'd4},  // R4 -128
        '{8'h2E, 32'h0000_0010, 24'h7F,      4'd14, 1'b0, 32'h0000_008F, 3'd2, 1'b0, 8'd4},  // R4 +127
        '{8'h3B, 32'h0001_0000, 24'h1234,    4'd1,  1'b0, 32'h0001_1234, 3'd3, 1'b0, 8'd5},  // R5 little endian
        '{8'h38, 32'h0000_8000, 24'h8000,    4'd14, 1'b0, 32'h0000_0000, 3'd3, 1'b0, 8'd5},  // R5 -32768
        '{8'h3A, 32'h0000_0020, 24'h0002,    4'd0,  1'b0, 32'h0000_0022, 3'd3, 1'b0, 8'd5},  // R5 cond 0
        '{8'h04, 32'h0100_0000, 24'h123456,  4'd14, 1'b0, 32'h0112_3456, 3'd4, 1'b0, 8'd6},  // R6
        '{8'h04, 32'h0000_0000, 24'hFFFFFF,  4'd14, 1'b0, 32'hFFFF_FFFF, 3'd4, 1'b0, 8'd8},  // R8 below zero
        '{8'h39, 32'h0000_0500, 24'hFFFE,    4'd14, 1'b1, 32'h0000_04FE, 3'd3, 1'b0, 8'd7},  // R7 word call
        '{8'h05, 32'h0090_0000, 24'h800000,  4'd14, 1'b1, 32'h0010_0000, 3'd4, 1'b0, 8'd7},  // R7 long call
        '{8'h00, 32'h0000_1234, 24'h0,       4'd0,  1'b0, 32'h0000_0000, 3'd0, 1'b1, 8'd9},  // R9
        '{8'h3C, 32'h0000_1234, 24'h0,       4'd0,  1'b0, 32'h0000_0000, 3'd0, 1'b1, 8'd9},  // R9
        '{8'h06, 32'h0000_1234, 24'h0,       4'd0,  1'b0, 32'h0000_0000, 3'd0, 1'b1, 8'd9},  // R9
        '{8'hFF, 32'h0000_1234, 24'h0,       4'd0,  1'b0, 32'h0000_0000, 3'd0, 1'b1, 8'd9}   // R9
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", nerr, nchecks);
    endtask

    task automatic run_vec(input vec_t v);
        int    nb;
        string rq;
        nb = v.inv ? 0 : int'(v.len) - 1;
        rq = $sformatf("R%0d", v.req);
        op_valid = 1'b1; op_byte = v.op; op_pc = v.pc;
        @(posedge clk); #1;
        op_valid = 1'b0;
        for (int k = 0; k < nb; k++) begin
            chk("R11", "busy while gathering", busy, 1);
            chk("R10", "no early result", res_valid, 0);
            nb_valid = 1'b1; nb_data = v.bytes[k*8 +: 8];
            @(posedge clk); #1;
            nb_valid = 1'b0;
        end
        chk("R10", "result strobe", res_valid, 1);
        chk(rq, "target",  res_target, v.tgt);
        chk(rq, "cond",    res_cond, v.cond);
        chk(rq, "call",    res_call, v.call);
        chk(rq, "length",  res_len, v.len);
        chk(rq, "invalid", res_invalid, v.inv);
        chk("R11", "idle after result", busy, 0);
        @(posedge clk); #1;
        chk("R10", "strobe is one cycle", res_valid, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchecks++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12", "reset res_valid", res_valid, 0);
        chk("R12", "reset busy", busy, 0);
        chk("R12", "reset target", res_target, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R12", "after reset len", res_len, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R11: a stall cycle without nb_valid just waits
        op_valid = 1'b1; op_byte = 8'h3B; op_pc = 32'h100;
        @(posedge clk); #1; op_valid = 1'b0;
        nb_valid = 1'b1; nb_data = 8'h10;
        @(posedge clk); #1; nb_valid = 1'b0;
        @(posedge clk); #1;
        chk("R11", "stall keeps busy", busy, 1);
        chk("R11", "stall no result", res_valid, 0);
        nb_valid = 1'b1; nb_data = 8'h00;
        @(posedge clk); #1; nb_valid = 1'b0;
        chk("R11", "stall result strobe", res_valid, 1);
        chk("R11", "stall target", res_target, 32'h110);

        // R11: an opcode offered while gathering is ignored
        @(posedge clk); #1;
        op_valid = 1'b1; op_byte = 8'h25; op_pc = 32'h0;
        @(posedge clk); #1;
        op_byte = 8'h10; op_pc = 32'h5000;
        nb_valid = 1'b1; nb_data = 8'h04;
        @(posedge clk); #1;
        op_valid = 1'b0; nb_valid = 1'b0;
        chk("R11", "busy-time op target", res_target, 32'h4);
        chk("R11", "busy-time op cond", res_cond, 4'd5);
        chk("R11", "busy-time op len", res_len, 3'd2);
        @(posedge clk); #1;
        chk("R11", "no second result", res_valid, 0);
        chk("R11", "no second fetch", busy, 0);

        // R11: an offset byte offered while idle is ignored
        nb_valid = 1'b1; nb_data = 8'h55;
        @(posedge clk); #1; nb_valid = 1'b0;
        chk("R11", "idle byte no result", res_valid, 0);
        chk("R11", "idle byte no busy", busy, 0);
        run_vec('{8'h2E, 32'h0, 24'h01, 4'd14, 1'b0, 32'h1, 3'd2, 1'b0, 8'd11});

        summary();
        $finish;
    end

endmodule